// File: doc/BRIEF.md
# Eight-Times Oversampled Serial Byte Receiver

This block recovers 8-bit characters from an asynchronous serial line. An enable pulse, `baud_tick`, arrives at eight times the bit rate. The receiver first passes the line through a small synchronizer. It then finds the falling edge of a start bit and confirms that bit half a bit later. After that it samples each data bit near its centre, LSB first. It can also check a parity bit, and it samples the stop bit last.

Each finished character goes into a receive data register. A status register holds four flags:

- full
- framing error
- parity error
- overrun

The interrupt output is high whenever the full flag is set.

A simple single-cycle register port gives access to the registers. Software reads the data and status registers through it, and writes the two-bit parity control register. Reads have side effects:

- A status read clears the error flags.
- Only a data read empties the full flag.

A stop bit sampled low raises a framing error. The receiver then returns at once to hunting for a start bit. If the line is still low, it takes that level as a new start bit, and this can produce a second framing error.

Top module: `uart8x_rx`

## Requirements
- R1: After synchronous reset, the registers read as follows: status (address 1) reads 0x00, data (address 0) reads 0x00 and control (address 2) reads 0x00. `irq` is low.
- R2: The receiver counts eight `baud_tick` pulses per bit. A frame is a low start bit, then eight data bits LSB first, then an optional parity bit, then a stop bit. When a frame ends, the eight data bits are stored in the data register and status bit 0 (full) is set.
- R3: `irq` is high exactly while status bit 0 (full) is set.
- R4: A data register read is the only thing that clears the full flag. A status read leaves the full flag set.
- R5: A status read returns the flags as they were before the read. It then clears status bits 1 (framing), 2 (parity) and 3 (overrun). If a frame completes in the same cycle, its flags win.
- R6: A stop bit sampled low sets status bit 1. The byte is still stored. If the line stays low, it is treated as the start bit of the next frame, and that frame can set status bit 1 again.
- R7: Control bit 0 enables parity and control bit 1 selects odd parity (0 selects even). When parity is enabled, the parity bit follows the data bits. Even parity expects the XOR of the data bits. Odd parity expects its inverse. A mismatch sets status bit 2.
- R8: If a frame completes while the full flag is set and the data register is not being read, status bit 3 (overrun) is set. The stored byte is kept.
- R9: A start bit is accepted only if the line is still low at the fourth tick after the falling edge was seen. A shorter low pulse stores nothing and sets no flag.
- R10: Bit timing counts only the cycles in which `baud_tick` is high. Reception works unchanged when ticks arrive on only every third clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at eight times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data, 1 status, 2 control |
| bus_wdata | input | 2 | Control write value |
| bus_rdata | output | 8 | Read value for `bus_addr`, combinational |
| irq | output | 1 | Receive-full interrupt level |

## Verification
The assertions assume the following about the inputs:

- Each register access is a one-cycle strobe with a stable address, so a read side effect happens exactly once per access.
- `baud_tick` is a one-cycle pulse at most once per clock.

The bench keeps to these rules. It drives every bus strobe for exactly one clock edge, makes the tick from a divider, and changes `rxd` only on falling clock edges so that each bit lasts exactly eight ticks. The bench also places the line transitions of the framing-cascade and start-glitch cases at known tick offsets. This puts each sample point at least two ticks away from an edge, so the synchronizer latency cannot change the outcome.

// File: rtl/uart8x_rx_pkg.sv
package uart8x_rx_pkg;

    localparam int DATA_W = 8;
    localparam int STAT_W = 4;
    localparam int CTRL_W = 2;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DATA   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } rx_state_e;

    // bit 1 odd, bit 0 enable
    typedef struct packed {
        logic odd;
        logic en;
    } rx_ctrl_t;

    // bit 3 overrun, bit 2 parity, bit 1 framing, bit 0 full
    typedef struct packed {
        logic overrun;
        logic parity_err;
        logic frame_err;
        logic full;
    } rx_status_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              frame_err;
        logic              parity_err;
    } rx_frame_t;

    function automatic logic expected_parity(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import uart8x_rx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx,
    input  rx_ctrl_t  ctrl,
    output logic      done_o,
    output rx_frame_t frame_o
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(DATA_W);
    localparam int HALF = OVS / 2;

    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] CNT_MID  = CW'(HALF - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

    rx_state_e         state_q;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              perr_q;
    logic              fe_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            perr_q  <= 1'b0;
            fe_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    S_IDLE: begin
                        if (!rx) begin
                            state_q <= S_START;
                            cnt_q   <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt_q == CNT_MID) begin
                            cnt_q <= '0;
                            if (!rx) begin
                                state_q <= S_DATA;
                                bit_q   <= '0;
                                perr_q  <= 1'b0;
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q <= '0;
                            sh_q  <= {rx, sh_q[DATA_W-1:1]};
                            if (bit_q == BIT_LAST) state_q <= ctrl.en ? S_PARITY : S_STOP;
                            else                   bit_q   <= bit_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    S_PARITY: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q   <= '0;
                            perr_q  <= (rx != expected_parity(sh_q, ctrl.odd));
                            state_q <= S_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q   <= '0;
                            fe_q    <= !rx;
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    assign done_o  = done_q;
    assign frame_o = '{data: sh_q, frame_err: fe_q, parity_err: perr_q};

    // R9: a high line at the start check sends the framer back to idle
    p_start_reject_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_START && tick && cnt_q == CNT_MID && rx) |=> (state_q == S_IDLE && !done_o));

    // R6: a low stop sample yields a completed frame flagged with a framing error
    p_stop_low_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_STOP && tick && cnt_q == CNT_LAST && !rx) |=> (done_o && frame_o.frame_err));

    // R2: completion is a single-cycle pulse
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: rtl/rx_regs.sv
module rx_regs
    import uart8x_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_frame_t         frame,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output rx_ctrl_t          ctrl,
    output logic              irq
);
    logic [DATA_W-1:0] data_q;
    rx_status_t        st_q;
    rx_ctrl_t          ctrl_q;

    logic rd_data, rd_status, wr_ctrl;
    assign rd_data   = sel && !wr && addr == A_DATA;
    assign rd_status = sel && !wr && addr == A_STATUS;
    assign wr_ctrl   = sel &&  wr && addr == A_CTRL;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            st_q   <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= rx_ctrl_t'(wdata);
            if (done) begin
                if (!st_q.full || rd_data) data_q <= frame.data;
                st_q.full       <= 1'b1;
                st_q.overrun    <= (st_q.full && !rd_data) || (st_q.overrun && !rd_status);
                st_q.frame_err  <= frame.frame_err  || (st_q.frame_err  && !rd_status);
                st_q.parity_err <= frame.parity_err || (st_q.parity_err && !rd_status);
            end else begin
                if (rd_data) st_q.full <= 1'b0;
                if (rd_status) begin
                    st_q.overrun    <= 1'b0;
                    st_q.frame_err  <= 1'b0;
                    st_q.parity_err <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_DATA:   rdata = data_q;
            A_STATUS: rdata = DATA_W'(st_q);
            A_CTRL:   rdata = DATA_W'(ctrl_q);
            default:  rdata = '0;
        endcase
    end

    assign ctrl = ctrl_q;
    assign irq  = st_q.full;

    // R4: nothing but a data read empties the full flag
    p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.full && !rd_data) |=> st_q.full);

    // R5: a status read with no completing frame leaves all error flags clear
    p_status_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !done) |=> (!st_q.overrun && !st_q.parity_err && !st_q.frame_err));

    // R8: a frame landing on a full register flags overrun and keeps the old byte
    p_overrun_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (done && st_q.full && !rd_data) |=> (st_q.overrun && $stable(data_q)));

    // R3: interrupt is never high without the full flag
    p_irq_full_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rdata != 8'h00 || addr != A_STATUS));
endmodule

// File: rtl/uart8x_rx.sv
module uart8x_rx
    import uart8x_rx_pkg::*;
#(
    parameter int OVS         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        baud_tick,
    input  logic        rxd,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [1:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq
);
    logic      rx_s;
    logic      done;
    rx_frame_t frame;
    rx_ctrl_t  ctrl;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_s)
    );

    rx_framer #(.OVS(OVS)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick),
        .rx      (rx_s),
        .ctrl    (ctrl),
        .done_o  (done),
        .frame_o (frame)
    );

    rx_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .done  (done),
        .frame (frame),
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .ctrl  (ctrl),
        .irq   (irq)
    );
endmodule

// File: tb/tb_uart8x_rx.sv
`timescale 1ns/1ps
module tb_uart8x_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [1:0] bus_wdata = 2'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int total = 0;
    int failed = 0;
    int div = 1;
    int tcnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uart8x_rx dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(negedge clk) begin
        if (tcnt >= div - 1) begin baud_tick = 1'b1; tcnt = 0; end
        else begin baud_tick = 1'b0; tcnt = tcnt + 1; end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!baud_tick);
        end
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk);
        rxd = v;
        wait_ticks(8);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit with_par, input logic par, input logic stop_v);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        if (with_par) send_bit(par);
        send_bit(stop_v);
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_byte(input string req, input logic [7:0] b, input logic [7:0] st);
        logic [7:0] v;
        chk({req, " irq set"}, {7'd0, irq}, 8'h01);
        bus_read(2'd1, v); chk({req, " status"}, v, st);
        bus_read(2'd0, v); chk({req, " data"}, v, b);
        bus_read(2'd1, v); chk({req, " status after reads"}, v, 8'h00);
        chk("R3 irq low after data read", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        bus_read(2'd1, v); chk("R1 status", v, 8'h00);
        bus_read(2'd0, v); chk("R1 data", v, 8'h00);
        bus_read(2'd2, v); chk("R1 control", v, 8'h00);

        // R2 R3 exhaustive byte sweep, parity off
        for (int b = 0; b < 256; b++) begin
            send_frame(8'(b), 1'b0, 1'b0, 1'b1);
            wait_ticks(8);
            expect_byte("R2", 8'(b), 8'h01);
        end

        // R4 status read does not clear full
        send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
        wait_ticks(8);
        bus_read(2'd1, v); chk("R4 first status read", v, 8'h01);
        bus_read(2'd1, v); chk("R4 second status read keeps full", v, 8'h01);
        chk("R4 irq still high", {7'd0, irq}, 8'h01);
        bus_read(2'd0, v); chk("R4 data", v, 8'h5A);
        chk("R4 irq low after data read", {7'd0, irq}, 8'h00);

        // R7 parity even and odd, correct then wrong
        for (int m = 0; m < 2; m++) begin
            bus_write(2'd2, {1'(m), 1'b1});
            bus_read(2'd2, v); chk("R7 control readback", v, {6'd0, 1'(m), 1'b1});
            for (int b = 0; b < 64; b++) begin
                logic [7:0] d;
                logic p;
                d = 8'(b * 37 + m * 11);
                p = (^d) ^ 1'(m);
                send_frame(d, 1'b1, p, 1'b1);
                wait_ticks(8);
                expect_byte("R7 good parity", d, 8'h01);
            end
            for (int b = 0; b < 8; b++) begin
                logic [7:0] d;
                d = 8'(b * 53 + 3);
                send_frame(d, 1'b1, ~((^d) ^ 1'(m)), 1'b1);
                wait_ticks(8);
                expect_byte("R7 parity error R5", d, 8'h05);
            end
        end
        bus_write(2'd2, 2'd0);

        // R8 overrun keeps first byte
        send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
        wait_ticks(8);
        expect_byte("R8 overrun", 8'hC3, 8'h09);

        // R9 start glitch of three ticks rejected
        @(negedge clk) rxd = 1'b0;
        wait_ticks(3);
        @(negedge clk) rxd = 1'b1;
        wait_ticks(40);
        bus_read(2'd1, v); chk("R9 glitch leaves status clear", v, 8'h00);
        chk("R9 glitch no irq", {7'd0, irq}, 8'h00);
        send_frame(8'h81, 1'b0, 1'b0, 1'b1);
        wait_ticks(8);
        expect_byte("R9 frame after glitch", 8'h81, 8'h01);

        // R6 framing error and cascade
        send_frame(8'hA5, 1'b0, 1'b0, 1'b0);
        fork
            begin
                wait_ticks(76);
                @(negedge clk) rxd = 1'b1;
            end
            begin
                repeat (4) @(posedge clk);
                bus_read(2'd1, v); chk("R6 first framing error", v, 8'h03);
                bus_read(2'd0, v); chk("R6 first byte kept", v, 8'hA5);
            end
        join
        wait_ticks(40);
        bus_read(2'd1, v); chk("R6 cascaded framing error", v, 8'h03);
        bus_read(2'd0, v); chk("R6 cascaded byte is zero", v, 8'h00);
        bus_read(2'd1, v); chk("R6 status clear after cascade", v, 8'h00);

        // R10 ticks on every third clock
        div = 3;
        wait_ticks(4);
        send_frame(8'h96, 1'b0, 1'b0, 1'b1);
        wait_ticks(8);
        expect_byte("R10 slow tick", 8'h96, 8'h01);
        send_frame(8'h0F, 1'b0, 1'b0, 1'b1);
        wait_ticks(8);
        expect_byte("R10 slow tick second", 8'h0F, 8'h01);

        finished = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; failed++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule